// File: doc/BRIEF.md
# Transport Stream Energy-Dispersal Descrambler

This block sits after the outer error-correction decoder in a satellite receive chain. It takes corrected transport packets one byte per valid cycle, with a strobe on the first byte of each packet. It removes the energy-dispersal scrambling that the transmitter applied. The keystream comes from a 15-stage pseudo-random generator with polynomial 1 + x^14 + x^15. The transmitter restarts that generator once per group of eight packets and marks the restart by sending the group's first sync byte as 0xB8 instead of 0x47. The block spots the marked sync byte, reloads its generator, and writes the byte back out as 0x47.

Packet sync bytes are never descrambled. The generator keeps stepping across the seven ordinary sync bytes of a group, so the keystream stays aligned with the transmitter. Until the first marked sync byte arrives, bytes pass through untouched and a status output reports that the block is unlocked. A bypass input turns descrambling off completely. Every output is registered, so results appear one clock after the byte is presented. The reset `rst_n` is asynchronous and active low, and it must be released synchronously to `clk`.

Top module: `ts_energy_descrambler`

## Requirements
- R1: While reset is asserted and after it is released, with no input yet accepted, `out_valid` = 0, `out_start` = 0, `out_data` = 0x00 and `unlocked` = 1.
- R2: Latency is one cycle. `out_valid` equals `in_valid` of the previous cycle, and `out_start` equals `in_valid & in_start` of the previous cycle.
- R3: While `unlocked` = 1 and `bypass` = 0, every accepted byte except a start-flagged 0xB8 is output unchanged.
- R4: An accepted byte with `in_start` = 1, value 0xB8 and `bypass` = 0 is output as 0x47 with `out_start` = 1, and `unlocked` is 0 from the next cycle on.
- R5: On that byte the generator stages 1..15 are loaded with 1,0,0,1,0,1,0,1,0,0,0,0,0,0,0. Each step outputs stage14 XOR stage15, shifts stage i into stage i+1, and feeds the output into stage 1.
- R6: When locked, each accepted data byte (`in_start` = 0) is XORed with the next 8 generator outputs, the first output landing on bit 7 (MSB) and the last on bit 0. The first data byte after a 0xB8 start byte is therefore XORed with 0x03.
- R7: A start-flagged byte of 0x47 is output as 0x47, and while locked the generator still advances 8 steps for it.
- R8: With `bypass` = 1, an accepted byte is output exactly as received, including a start-flagged 0xB8. After such a byte `unlocked` = 1, and a new start-flagged 0xB8 is needed to descramble again.
- R9: A 0xB8 without the start flag is ordinary data, XORed when locked. A start-flagged byte other than 0x47 or 0xB8 is passed unchanged and, when locked, advances the generator by 8 steps.
- R10: A cycle with `in_valid` = 0 leaves `out_data`, `unlocked` and the generator state unchanged.
- R11: Every start-flagged 0xB8 reloads the seed, even while already locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte qualifier |
| in_start | input | 1 | Input byte is the first of a packet |
| in_data | input | 8 | Input byte |
| bypass | input | 1 | Pass bytes through with no descrambling |
| out_valid | output | 1 | Output byte qualifier |
| out_start | output | 1 | Output byte is the first of a packet |
| out_data | output | 8 | Descrambled byte |
| unlocked | output | 1 | No group-start sync byte seen since reset or bypass |

## Verification
A wrong generator state cannot be hidden. It corrupts the very next data byte after a group-start sync byte, and the first byte of keystream, 0x03, is known in advance. A slip in the step count or the bit order shows up as a mismatch within one packet. A generator that is wrongly stepped or frozen on sync bytes or idle cycles shows up on the first data byte after that sync byte or gap. A lock flag that is set or cleared at the wrong time shows up at once: bytes come out scrambled or left in the clear, and the `unlocked` output shows the same error in the same cycle.

// File: rtl/ts_descr_pkg.sv
package ts_descr_pkg;

  typedef enum logic [1:0] {
    BK_DATA        = 2'd0,
    BK_SYNC_PLAIN  = 2'd1,
    BK_SYNC_INV    = 2'd2,
    BK_START_OTHER = 2'd3
  } byte_kind_e;

endpackage

// File: rtl/ts_byte_classifier.sv
module ts_byte_classifier
  import ts_descr_pkg::*;
#(
  parameter int unsigned        DATA_W    = 8,
  parameter logic [DATA_W-1:0]  SYNC_NORM = 8'h47,
  parameter logic [DATA_W-1:0]  SYNC_INV  = 8'hB8
) (
  input  logic              is_start,
  input  logic [DATA_W-1:0] byte_in,
  output byte_kind_e        kind
);

  always_comb begin
    kind = BK_DATA;
    if (is_start) begin
      if (byte_in == SYNC_INV)       kind = BK_SYNC_INV;
      else if (byte_in == SYNC_NORM) kind = BK_SYNC_PLAIN;
      else                           kind = BK_START_OTHER;
    end
  end

endmodule

// File: rtl/ts_prbs_keystream.sv
module ts_prbs_keystream #(
  parameter int unsigned          SR_W   = 15,
  parameter int unsigned          TAP_LO = 13,
  parameter int unsigned          TAP_HI = 14,
  parameter int unsigned          KS_W   = 8,
  parameter logic [SR_W-1:0]      SEED   = 15'h00A9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            advance,
  output logic [KS_W-1:0] keystream
);

  logic [SR_W-1:0] state_q;
  logic [SR_W-1:0] state_d;
  logic [SR_W-1:0] stepped;

  // KS_W generator steps unrolled; first output lands on the MSB.
  always_comb begin
    logic [SR_W-1:0] walk;
    logic            fb;
    walk      = state_q;
    keystream = '0;
    for (int k = 0; k < int'(KS_W); k++) begin
      fb = walk[TAP_LO] ^ walk[TAP_HI];
      keystream[KS_W-1-k] = fb;
      walk = {walk[SR_W-2:0], fb};
    end
    stepped = walk;
  end

  always_comb begin
    state_d = state_q;
    if (load)         state_d = SEED;
    else if (advance) state_d = stepped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              state_q <= SEED;
    else if (load | advance) state_q <= state_d;
  end

  assert_seed_reload_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> state_q == SEED)
    else $error("generator not reloaded with seed");

  assert_never_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0)
    else $error("generator reached all-zero state");

  assert_advance_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> state_q != $past(state_q))
    else $error("generator did not move on advance");

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !load) |=> $stable(state_q))
    else $error("generator moved without advance");

endmodule

// File: rtl/ts_lock_tracker.sv
module ts_lock_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic byte_en,
  input  logic bypass,
  input  logic inv_sync,
  output logic unlocked
);

  logic unlocked_q;
  logic unlocked_d;

  always_comb begin
    unlocked_d = unlocked_q;
    if (byte_en) begin
      if (bypass)        unlocked_d = 1'b1;
      else if (inv_sync) unlocked_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       unlocked_q <= 1'b1;
    else if (byte_en) unlocked_q <= unlocked_d;
  end

  assign unlocked = unlocked_q;

  assert_lock_only_on_inv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unlocked_q) |-> $past(byte_en && inv_sync && !bypass))
    else $error("lock gained without inverted sync");

  assert_bypass_unlocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_en && bypass) |=> unlocked_q)
    else $error("bypass did not drop lock");

endmodule

// File: rtl/ts_energy_descrambler.sv
module ts_energy_descrambler
  import ts_descr_pkg::*;
#(
  parameter int unsigned          DATA_W     = 8,
  parameter logic [DATA_W-1:0]    SYNC_NORM  = 8'h47,
  parameter logic [DATA_W-1:0]    SYNC_INV   = 8'hB8,
  parameter int unsigned          PRBS_W     = 15,
  parameter int unsigned          PRBS_EXP_A = 14,
  parameter int unsigned          PRBS_EXP_B = 15,
  parameter logic [PRBS_W-1:0]    PRBS_SEED  = 15'h00A9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_start,
  input  logic [DATA_W-1:0] in_data,
  input  logic              bypass,
  output logic              out_valid,
  output logic              out_start,
  output logic [DATA_W-1:0] out_data,
  output logic              unlocked
);

  localparam int unsigned TAP_LO = PRBS_EXP_A - 1;
  localparam int unsigned TAP_HI = PRBS_EXP_B - 1;

  byte_kind_e        kind;
  logic [DATA_W-1:0] keystream;
  logic              active;
  logic              prbs_load;
  logic              prbs_adv;
  logic              lock_q_n;
  logic              data_en;

  logic              valid_d, start_d;
  logic [DATA_W-1:0] data_d;
  logic              valid_q, start_q;
  logic [DATA_W-1:0] data_q;

  ts_byte_classifier #(
    .DATA_W    (DATA_W),
    .SYNC_NORM (SYNC_NORM),
    .SYNC_INV  (SYNC_INV)
  ) u_classify (
    .is_start (in_valid & in_start),
    .byte_in  (in_data),
    .kind     (kind)
  );

  ts_prbs_keystream #(
    .SR_W   (PRBS_W),
    .TAP_LO (TAP_LO),
    .TAP_HI (TAP_HI),
    .KS_W   (DATA_W),
    .SEED   (PRBS_SEED)
  ) u_prbs (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (prbs_load),
    .advance   (prbs_adv),
    .keystream (keystream)
  );

  ts_lock_tracker u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_en  (in_valid),
    .bypass   (bypass),
    .inv_sync (kind == BK_SYNC_INV),
    .unlocked (lock_q_n)
  );

  assign active    = in_valid & ~bypass;
  assign prbs_load = active & (kind == BK_SYNC_INV);
  assign prbs_adv  = active & ~lock_q_n & (kind != BK_SYNC_INV);
  assign data_en   = in_valid;

  // Output byte selection.
  always_comb begin
    valid_d = in_valid;
    start_d = in_valid & in_start;
    data_d  = in_data;
    if (!bypass) begin
      unique case (kind)
        BK_SYNC_INV:    data_d = SYNC_NORM;
        BK_DATA:        data_d = lock_q_n ? in_data : (in_data ^ keystream);
        BK_SYNC_PLAIN,
        BK_START_OTHER: data_d = in_data;
        default:        data_d = in_data;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      start_q <= start_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign out_valid = valid_q;
  assign out_start = start_q;
  assign out_data  = data_q;
  assign unlocked  = lock_q_n;

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid)
    else $error("valid byte not presented after one cycle");

  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !out_start)
    else $error("output qualifier without input");

  assert_clear_passthrough_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && unlocked && !bypass && !(in_start && in_data == SYNC_INV))
      |=> out_data == $past(in_data))
    else $error("byte altered while unlocked");

  assert_inv_sync_restored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_start && !bypass && in_data == SYNC_INV)
      |=> out_data == SYNC_NORM && out_start && !unlocked)
    else $error("inverted sync not restored");

  assert_plain_sync_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_start && in_data == SYNC_NORM) |=> out_data == SYNC_NORM)
    else $error("plain sync byte altered");

  assert_bypass_transparent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && bypass) |=> out_data == $past(in_data) && unlocked)
    else $error("bypass byte altered");

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data) && $stable(unlocked))
    else $error("state changed on idle cycle");

endmodule

// File: tb/tb_ts_energy_descrambler.sv
`timescale 1ns/1ps
module tb_ts_energy_descrambler;

  localparam int PKT_LEN = 12;

  logic       clk;
  logic       rst_n;
  logic       in_valid, in_start, bypass;
  logic [7:0] in_data;
  logic       out_valid, out_start, unlocked;
  logic [7:0] out_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  // Reference model state: stages 1..15.
  bit [1:15] ref_r;
  bit        ref_locked;
  logic [7:0] exp_data;

  ts_energy_descrambler dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_data(in_data), .bypass(bypass), .out_valid(out_valid),
    .out_start(out_start), .out_data(out_data), .unlocked(unlocked)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_keystream();
    logic [7:0] ks;
    bit fb;
    ks = '0;
    for (int i = 0; i < 8; i++) begin
      fb = ref_r[14] ^ ref_r[15];
      for (int j = 15; j >= 2; j--) ref_r[j] = ref_r[j-1];
      ref_r[1] = fb;
      ks = {ks[6:0], fb};
    end
    return ks;
  endfunction

  function automatic void ref_step(input bit v, input bit s, input logic [7:0] d,
                                   input bit byp);
    logic [7:0] ks;
    if (!v) return;
    if (byp) begin
      ref_locked = 0;
      exp_data   = d;
    end else if (s && d == 8'hB8) begin
      ref_r      = 15'b100101010000000;
      ref_locked = 1;
      exp_data   = 8'h47;
    end else if (!ref_locked) begin
      exp_data = d;
    end else begin
      ks = ref_keystream();
      exp_data = s ? d : (d ^ ks);
    end
  endfunction

  task automatic send(input bit v, input bit s, input logic [7:0] d, input bit byp,
                      input string req);
    @(negedge clk);
    in_valid = v; in_start = s; in_data = d; bypass = byp;
    ref_step(v, s, d, byp);
    @(posedge clk);
    #1;
    check(out_valid == v, "R2", out_valid, v);
    check(out_start == (v & s), "R2", out_start, v & s);
    check(out_data == exp_data, req, out_data, exp_data);
    check(unlocked == !ref_locked, req, unlocked, !ref_locked);
  endtask

  task automatic send_packet(input bit first, input bit byp);
    send(1, 1, first ? 8'hB8 : 8'h47, byp, first ? "R4" : "R7");
    for (int b = 1; b < PKT_LEN; b++) begin
      if (($urandom % 5) == 0) send(0, 0, 8'($urandom), byp, "R10");
      if (($urandom % 9) == 0) send(1, 0, 8'hB8, byp, "R9");
      else                     send(1, 0, 8'($urandom), byp, "R6");
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0147));
    rst_n = 0; in_valid = 0; in_start = 0; in_data = 0; bypass = 0;
    ref_locked = 0; ref_r = '0; exp_data = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 0 && out_start == 0, "R1", {out_valid, out_start}, 0);
    check(out_data == 8'h00, "R1", out_data, 8'h00);
    check(unlocked == 1, "R1", unlocked, 1);
    @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    check(unlocked == 1 && out_valid == 0, "R1", {unlocked, out_valid}, 2'b10);

    // Unlocked: everything in the clear, incl. 0xB8 without start flag.
    send(1, 1, 8'h47, 0, "R3");
    send(1, 0, 8'h5A, 0, "R3");
    send(1, 0, 8'hB8, 0, "R9");
    send(1, 1, 8'h12, 0, "R3");

    // First group start: restore sync, then the known first keystream byte.
    send(1, 1, 8'hB8, 0, "R4");
    send(1, 0, 8'h00, 0, "R6");
    check(out_data == 8'h03, "R5", out_data, 8'h03);
    send(0, 0, 8'h00, 0, "R10");
    send(1, 0, 8'hFF, 0, "R10");
    send(1, 1, 8'h47, 0, "R7");
    send(1, 1, 8'h3C, 0, "R9");
    send(1, 0, 8'hA5, 0, "R7");

    // Random groups of eight packets.
    for (int g = 0; g < 3; g++)
      for (int p = 0; p < 8; p++) send_packet(p == 0, 0);

    // Bypass section, including a marked sync byte left untouched.
    send(1, 1, 8'hB8, 1, "R8");
    for (int i = 0; i < 6; i++) send(1, 0, 8'($urandom), 1, "R8");
    // After bypass the block needs a fresh marked sync.
    send(1, 1, 8'h47, 0, "R8");
    send(1, 0, 8'h77, 0, "R8");

    // Reload mid-group while locked.
    send(1, 1, 8'hB8, 0, "R11");
    send(1, 0, 8'h11, 0, "R11");
    send(1, 1, 8'h47, 0, "R11");
    send(1, 1, 8'hB8, 0, "R11");
    send(1, 0, 8'h00, 0, "R11");
    check(out_data == 8'h03, "R11", out_data, 8'h03);

    for (int g = 0; g < 2; g++)
      for (int p = 0; p < 8; p++) send_packet(p == 0, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

endmodule